// File: doc/BRIEF.md
# Banked Scratchpad Crossbar

This block lets a group of requesters share one scratchpad memory built from several independent SRAM banks. Each requester has a request/grant port. A requester drives an address, a write flag, four byte enables and write data. If the request wins in the same cycle, the grant comes back combinationally. Banks are chosen by word address, so consecutive 32-bit words fall in different banks. A sequential stream from one requester therefore walks through all banks, and traffic from many requesters spreads out.

Each bank has its own round-robin arbiter. Requesters that target different banks are all served in the same cycle. When several requesters target one bank, one of them is granted. The others keep their request held until they win. A granted read returns its data with a valid strobe on the clock edge after the grant. Writes honour the byte enables. The bank count defaults to twice the requester count so that conflicts stay rare.

Top module: `spm_xbar`

## Requirements
- R1: The bank of an access is byte-address bits [2 +: log2(N_BANKS)]. The row inside the bank comes from the bits above them. With the defaults (8 banks, 64 rows), word n sits in bank n mod 8, row n div 8, and distinct words never alias.
- R2: Every requesting port whose bank no other port requests in that cycle is granted in that same cycle.
- R3: At most one port is granted per bank per cycle.
- R4: Each bank's arbiter searches round-robin, starting at the port after the last one it granted. After reset the search starts at port 0. A held request waits fewer than N_MASTERS cycles.
- R5: A grant is asserted only for a port that is requesting in that cycle.
- R6: A granted read sets that port's response valid, with the addressed word, exactly one cycle after the grant. Writes and ungranted requests produce no response valid.
- R7: A write changes only the bytes whose enable bit is 1. Enable bit k covers data bits [8k+7:8k].
- R8: While reset (active low, synchronous) is asserted, no grant and no response valid is given. Reset also returns every arbiter's search start to port 0.
- R9: Address bits [1:0] have no effect on which word is accessed.
- R10: A port that is requesting but not granted keeps its request, address and write flag unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_MASTERS | Request per port |
| addr_i | input | N_MASTERS x ADDR_W | Byte address per port |
| we_i | input | N_MASTERS | 1 = write, 0 = read |
| be_i | input | N_MASTERS x 4 | Byte enables per port |
| wdata_i | input | N_MASTERS x 32 | Write data per port |
| gnt_o | output | N_MASTERS | Grant, same cycle as the request |
| rvalid_o | output | N_MASTERS | Read response valid |
| rdata_o | output | N_MASTERS x 32 | Read response data |

## Verification
Two things can happen in one cycle. One port can be granted a fresh access to a bank while another port collects the read response from an earlier grant. At the same time, other ports can be stalled on a conflict. The bench provokes this by having three ports hold requests to one bank. It then checks, cycle by cycle, that the grant vector follows the round-robin order expected from that bank's earlier history. In the same cycle it checks that the port granted first receives its read data while the other two are still being arbitrated.

// File: rtl/spm_xbar_pkg.sv
// Shared widths and types for the banked scratchpad crossbar.
// Assumes 32-bit words with one enable bit per byte.
package spm_xbar_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;
endpackage

// File: rtl/spm_rr_arbiter.sv
// Round-robin arbiter for one bank.
// Grants the first requester found at or after the search pointer.
// The pointer then moves to the port after the winner.
// Assumes N >= 2.
module spm_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] win;
    logic             found;

    // Circular search for the first requester, starting at the pointer.
    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(ptr_q) + i) % N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win      = IDX_W'(idx);
            end
        end
    end

    // Move the pointer past the winner after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end
endmodule

// File: rtl/spm_bank.sv
// One single-port SRAM bank.
// Does a byte-masked write, or a registered read whose data is
// valid on the edge after the access.
// Contents are not reset.
module spm_bank #(
    parameter int WORDS = 64
) (
    input  logic                       clk,
    input  logic                       en,
    input  logic                       we,
    input  spm_xbar_pkg::be_t          be,
    input  logic [$clog2(WORDS)-1:0]   row,
    input  spm_xbar_pkg::word_t        wdata,
    output spm_xbar_pkg::word_t        rdata
);
    spm_xbar_pkg::word_t mem [WORDS];

    // Byte-masked write, or registered read of the addressed row.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int k = 0; k < spm_xbar_pkg::BE_W; k++) begin
                    if (be[k]) mem[row][8*k +: 8] <= wdata[8*k +: 8];
                end
            end else begin
                rdata <= mem[row];
            end
        end
    end
endmodule

// File: rtl/spm_xbar.sv
// Word-interleaved scratchpad crossbar.
// N_MASTERS ports reach N_BANKS banks through per-bank round-robin arbiters.
// Assumes N_BANKS and BANK_WORDS are powers of two.
// Assumes a stalled port holds its request stable until it is granted.
module spm_xbar
    import spm_xbar_pkg::*;
#(
    parameter int N_MASTERS  = 4,
    parameter int N_BANKS    = 2 * N_MASTERS,
    parameter int BANK_WORDS = 64,
    parameter int ADDR_W     = 2 + $clog2(N_BANKS) + $clog2(BANK_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_MASTERS-1:0]              req_i,
    input  logic [N_MASTERS-1:0][ADDR_W-1:0]  addr_i,
    input  logic [N_MASTERS-1:0]              we_i,
    input  logic [N_MASTERS-1:0][BE_W-1:0]    be_i,
    input  logic [N_MASTERS-1:0][DATA_W-1:0]  wdata_i,
    output logic [N_MASTERS-1:0]              gnt_o,
    output logic [N_MASTERS-1:0]              rvalid_o,
    output logic [N_MASTERS-1:0][DATA_W-1:0]  rdata_o
);
    localparam int BANK_BITS = $clog2(N_BANKS);
    localparam int ROW_BITS  = $clog2(BANK_WORDS);

    logic [N_MASTERS-1:0]                req_eff;
    logic [N_MASTERS-1:0][BANK_BITS-1:0] bank_sel;
    logic [N_MASTERS-1:0][ROW_BITS-1:0]  row_sel;
    logic [N_MASTERS-1:0]                bgnt   [N_BANKS];
    word_t                               brdata [N_BANKS];
    logic [N_MASTERS-1:0]                rvalid_q;
    logic [N_MASTERS-1:0][BANK_BITS-1:0] rbank_q;

    // Block requests during reset and split each address into bank and row.
    always_comb begin
        for (int m = 0; m < N_MASTERS; m++) begin
            req_eff[m]  = req_i[m] & rst_n;
            bank_sel[m] = addr_i[m][2 +: BANK_BITS];
            row_sel[m]  = addr_i[m][2 + BANK_BITS +: ROW_BITS];
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [N_MASTERS-1:0] breq;
        logic                 b_we;
        be_t                  b_be;
        logic [ROW_BITS-1:0]  b_row;
        word_t                b_wdata;

        // Collect the ports that address this bank.
        always_comb begin
            for (int m = 0; m < N_MASTERS; m++) begin
                breq[m] = req_eff[m] && (bank_sel[m] == BANK_BITS'(b));
            end
        end

        spm_rr_arbiter #(.N(N_MASTERS)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (breq),
            .gnt   (bgnt[b])
        );

        // One-hot mux that passes the winning port's fields to the bank.
        always_comb begin
            b_we    = 1'b0;
            b_be    = '0;
            b_row   = '0;
            b_wdata = '0;
            for (int m = 0; m < N_MASTERS; m++) begin
                if (bgnt[b][m]) begin
                    b_we    = b_we    | we_i[m];
                    b_be    = b_be    | be_i[m];
                    b_row   = b_row   | row_sel[m];
                    b_wdata = b_wdata | wdata_i[m];
                end
            end
        end

        spm_bank #(.WORDS(BANK_WORDS)) u_bank (
            .clk   (clk),
            .en    (|bgnt[b]),
            .we    (b_we),
            .be    (b_be),
            .row   (b_row),
            .wdata (b_wdata),
            .rdata (brdata[b])
        );
    end

    // A port is granted when any bank's arbiter picks it.
    always_comb begin
        gnt_o = '0;
        for (int b = 0; b < N_BANKS; b++) gnt_o = gnt_o | bgnt[b];
    end

    // Record granted reads so their data can be routed back next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= '0;
            rbank_q  <= '0;
        end else begin
            for (int m = 0; m < N_MASTERS; m++) begin
                rvalid_q[m] <= gnt_o[m] & ~we_i[m];
                if (gnt_o[m] && !we_i[m]) rbank_q[m] <= bank_sel[m];
            end
        end
    end

    // Return each port the data of the bank it read from.
    always_comb begin
        for (int m = 0; m < N_MASTERS; m++) rdata_o[m] = brdata[rbank_q[m]];
    end

    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/spm_xbar_checker.sv
// Protocol and arbitration properties of spm_xbar, watched from its ports.
// Bound to every spm_xbar instance by the bind statement at the end of this file.
module spm_xbar_checker #(
    parameter int N_MASTERS = 4,
    parameter int N_BANKS   = 8,
    parameter int ADDR_W    = 11
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [N_MASTERS-1:0]             req_i,
    input logic [N_MASTERS-1:0][ADDR_W-1:0] addr_i,
    input logic [N_MASTERS-1:0]             we_i,
    input logic [N_MASTERS-1:0]             gnt_o,
    input logic [N_MASTERS-1:0]             rvalid_o
);
    localparam int BANK_BITS = $clog2(N_BANKS);
    localparam int CNT_W     = $clog2(N_MASTERS + 1) + 1;

    logic [N_MASTERS-1:0] alone;
    logic [N_MASTERS-1:0] hits [N_BANKS];
    logic [CNT_W-1:0]     wait_cnt [N_MASTERS];

    // Mark ports whose bank no other port requests this cycle.
    always_comb begin
        for (int m = 0; m < N_MASTERS; m++) begin
            alone[m] = 1'b1;
            for (int o = 0; o < N_MASTERS; o++) begin
                if (o != m && req_i[o] &&
                    addr_i[o][2 +: BANK_BITS] == addr_i[m][2 +: BANK_BITS])
                    alone[m] = 1'b0;
            end
        end
    end

    // Granted ports, sorted by the bank their address selects.
    always_comb begin
        for (int b = 0; b < N_BANKS; b++) begin
            for (int m = 0; m < N_MASTERS; m++) begin
                hits[b][m] = gnt_o[m] && (addr_i[m][2 +: BANK_BITS] == BANK_BITS'(b));
            end
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank_chk
        assert_one_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hits[b]) <= 1);
    end

    for (genvar m = 0; m < N_MASTERS; m++) begin : g_port_chk
        // Count the cycles a held request has waited without a grant.
        always_ff @(posedge clk) begin
            if (!rst_n || !req_i[m] || gnt_o[m]) wait_cnt[m] <= '0;
            else                                 wait_cnt[m] <= wait_cnt[m] + 1'b1;
        end

        assert_free_bank_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[m] && alone[m]) |-> gnt_o[m]);
        assert_bounded_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_cnt[m]) < N_MASTERS);
        assert_gnt_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[m] |-> req_i[m]);
        assert_read_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[m] && !we_i[m]) |=> rvalid_o[m]);
        assert_no_stray_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(gnt_o[m] && !we_i[m]) |=> !rvalid_o[m]);
        assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[m] && !gnt_o[m]) |=> (req_i[m] && $stable(addr_i[m]) && $stable(we_i[m])));
    end
endmodule

bind spm_xbar spm_xbar_checker #(
    .N_MASTERS (N_MASTERS),
    .N_BANKS   (N_BANKS),
    .ADDR_W    (ADDR_W)
) u_spm_xbar_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .gnt_o    (gnt_o),
    .rvalid_o (rvalid_o)
);

// File: tb/spm_xbar_bench.sv
// Self-checking bench for spm_xbar with the default parameters
// (4 ports, 8 banks of 64 words).
module spm_xbar_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam int AW = 11;

    typedef struct packed {
        logic          we;
        logic [3:0]    be;
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
        logic [31:0]   exp;
    } op_t;

    // Single-port sequence: writes, then readbacks, plus byte-enable and byte-offset cases.
    localparam op_t OPS [11] = '{
        '{1'b1, 4'hF, 11'h000, 32'h1111_1111, 32'h0},
        '{1'b1, 4'hF, 11'h004, 32'h2222_2222, 32'h0},
        '{1'b1, 4'hF, 11'h01C, 32'h7777_7777, 32'h0},
        '{1'b1, 4'hF, 11'h020, 32'h8888_8888, 32'h0},
        '{1'b0, 4'h0, 11'h000, 32'h0,         32'h1111_1111},
        '{1'b0, 4'h0, 11'h020, 32'h0,         32'h8888_8888},
        '{1'b1, 4'h5, 11'h004, 32'hAABB_CCDD, 32'h0},
        '{1'b0, 4'h0, 11'h007, 32'h0,         32'h22BB_22DD},
        '{1'b0, 4'h0, 11'h01C, 32'h0,         32'h7777_7777},
        '{1'b1, 4'h8, 11'h000, 32'hEE00_0000, 32'h0},
        '{1'b0, 4'h0, 11'h002, 32'h0,         32'hEE11_1111}
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NM-1:0]             req = '0;
    logic [NM-1:0][AW-1:0]     addr = '0;
    logic [NM-1:0]             we = '0;
    logic [NM-1:0][3:0]        be = '0;
    logic [NM-1:0][31:0]       wdata = '0;
    logic [NM-1:0]             gnt;
    logic [NM-1:0]             rvalid;
    logic [NM-1:0][31:0]       rdata;

    int checks = 0;
    int fails  = 0;

    spm_xbar u_spm_xbar (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
        .be_i(be), .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input int m, input logic w, input logic [3:0] b,
                         input logic [AW-1:0] a, input logic [31:0] d);
        req[m] = 1'b1; we[m] = w; be[m] = b; addr[m] = a; wdata[m] = d;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R8: no grant and no response valid while reset is held
        repeat (3) @(negedge clk);
        drive(0, 1'b0, 4'h0, 11'h000, 32'h0);
        #1 chk("R8 gnt in reset", 32'(gnt), 32'h0);
        req = '0;
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R8 rvalid after reset", 32'(rvalid), 32'h0);

        // Table walk on port 0 alone: R1 R6 R7 R9
        foreach (OPS[i]) begin
            @(negedge clk);
            drive(0, OPS[i].we, OPS[i].be, OPS[i].addr, OPS[i].wdata);
            #1 chk("R2 single port grant", 32'(gnt), 32'h1);
            @(negedge clk);
            req = '0;
            #1 chk("R6 rvalid only for reads", 32'(rvalid[0]), 32'(!OPS[i].we));
            if (!OPS[i].we) chk("R1/R7/R9 readback", rdata[0], OPS[i].exp);
        end

        // R2: four writes to banks 2..5 are all granted in one cycle
        @(negedge clk);
        for (int m = 0; m < NM; m++)
            drive(m, 1'b1, 4'hF, AW'((2 + m) * 4), 32'hC0DE_0000 + 32'(m));
        #1 chk("R2 parallel write grant", 32'(gnt), 32'hF);
        @(negedge clk);
        req = '0;
        #1 chk("R6 no rvalid on writes", 32'(rvalid), 32'h0);
        @(negedge clk);
        for (int m = 0; m < NM; m++) drive(m, 1'b0, 4'h0, AW'((2 + m) * 4), 32'h0);
        #1 chk("R2 parallel read grant", 32'(gnt), 32'hF);
        @(negedge clk);
        req = '0;
        #1 chk("R6 parallel rvalid", 32'(rvalid), 32'hF);
        for (int m = 0; m < NM; m++) chk("R1 parallel readback", rdata[m], 32'hC0DE_0000 + 32'(m));

        // R3 R4: three ports hold reads to bank 3. Port 1 last won bank 3, so the order is 2, 0, 1.
        @(negedge clk);
        drive(0, 1'b0, 4'h0, 11'h04C, 32'h0);
        drive(1, 1'b0, 4'h0, 11'h02C, 32'h0);
        drive(2, 1'b0, 4'h0, 11'h00C, 32'h0);
        #1 chk("R3/R4 conflict cycle A", 32'(gnt), 32'h4);
        @(negedge clk);
        req[2] = 1'b0;
        #1 chk("R4 conflict cycle B", 32'(gnt), 32'h1);
        chk("R6 rvalid during conflict", 32'(rvalid), 32'h4);
        chk("R6 data during conflict", rdata[2], 32'hC0DE_0001);
        @(negedge clk);
        req[0] = 1'b0;
        #1 chk("R4 conflict cycle C", 32'(gnt), 32'h2);
        @(negedge clk);
        req = '0;

        // R8: a new reset returns every pointer to port 0, so port 1 beats port 2
        rst_n = 1'b0;
        @(negedge clk);
        #1 chk("R8 rvalid cleared", 32'(rvalid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1, 1'b0, 4'h0, 11'h02C, 32'h0);
        drive(2, 1'b0, 4'h0, 11'h00C, 32'h0);
        #1 chk("R8 pointer reset", 32'(gnt), 32'h2);
        @(negedge clk);
        req[1] = 1'b0;
        #1 chk("R4 second winner", 32'(gnt), 32'h4);
        @(negedge clk);
        req = '0;
        #1 chk("R6 readback after reset", rdata[2], 32'hC0DE_0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule